// File: doc/BRIEF.md
# I2C Address-Match Wakeup Controller

This block sits beside an I2C target interface and keeps watching the bus while the rest of the system sleeps. It holds a small control register: a wakeup-arm bit, three configuration bits (fast-mode select, input-filter select, clock prescaler select) and two read-only bits that mirror the synchronized SCL and SDA levels. It detects start and stop conditions, shifts in the first byte after every start and classifies it as an own-address match or as an extension code.

When the wakeup-arm bit is set, a matching first byte raises a wake pulse together with the usual interrupt. Stop-condition interrupts are withheld while armed. A request to enter the low-power STOP state is held off until a short guard period has run after arming. Clearing the arm bit by software without a preceding wakeup interrupt locks out master starts until the bus shows a start or stop. Wait release and transmit-data writes are refused while armed.

Top module: `i2c_wake_ctl`

## Requirements
- R1: While reset is active and in the first cycle after it, `ctrl_q` reads 8'h00.
- R2: `ctrl_q` bit 5 shows the SCL level and bit 4 the SDA level, each delayed by the two-flop synchronizer; writes never change them, and bits 6 and 1 read 0.
- R3: A write updates bits 3, 2 and 0 of `ctrl_q` from `wr_data` only when `if_en` is 0; with `if_en` at 1 those bits keep their value.
- R4: A write with `wr_data[7]`=1 sets the arm bit (`ctrl_q[7]`) only when `mst_busy`, `bus_busy`, `addr_hit` and `ext_hit` are all 0; otherwise the arm bit stays 0. A write with `wr_data[7]`=0 always clears it.
- R5: While the arm bit is 1, a stop condition produces no `irq`; while it is 0, a stop produces a one-cycle `irq` when `stop_ie` is 1 and none when it is 0.
- R6: The first byte after a start (address MSB first, R/W last, sampled on SCL rise) raises a one-cycle `irq` in the third clock edge after the eighth SCL rise reaches `scl_in`, when it is an address match or an extension code; `wake` pulses in the same cycle only when armed.
- R7: With the arm bit at 0, `stop_grant` follows `stop_req`; after the arm bit is set, `stop_grant` stays 0 during the first three cycles and follows `stop_req` from then on.
- R8: Clearing the arm bit by a write when no wake pulse occurred since it was set makes `start_ok` 0 despite `start_req` until the next start or stop condition; after a wake pulse the clear leaves `start_ok` equal to `start_req`. `start_ok` is also 0 while armed.
- R9: `wait_ok` and `txd_ok` follow `wait_req` and `txd_req` only while the arm bit is 0.
- R10: A first byte whose bits [7:4] are 0000 or bits [7:3] are 11110 sets `ext_hit` and not `addr_hit`.
- R11: A first byte whose bits [7:1] equal `own_addr` and that is not an extension code sets `addr_hit`; both flags clear on the next start or stop.
- R12: `bus_busy` becomes 1 on a start (SDA falling while SCL high) and 0 on a stop (SDA rising while SCL high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| own_addr | input | 7 | Own target address |
| if_en | input | 1 | Interface enabled; locks configuration bits |
| stop_ie | input | 1 | Stop-condition interrupt enable |
| mst_busy | input | 1 | Master operation in progress |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| ctrl_q | output | 8 | Control register read value |
| start_req | input | 1 | Request to issue a master start |
| start_ok | output | 1 | Master start request accepted |
| wait_req | input | 1 | Wait release request |
| wait_ok | output | 1 | Wait release accepted |
| txd_req | input | 1 | Transmit-data write request |
| txd_ok | output | 1 | Transmit-data write accepted |
| stop_req | input | 1 | Low-power STOP entry request |
| stop_grant | output | 1 | STOP entry allowed |
| irq | output | 1 | Interrupt pulse |
| wake | output | 1 | Wakeup pulse |
| bus_busy | output | 1 | Start seen, no stop since |
| addr_hit | output | 1 | First byte matched own address |
| ext_hit | output | 1 | First byte was an extension code |

## Verification
The bench builds the block with its default two synchronizer stages and a three-cycle STOP guard, and fixes the own address at 7'h5A. With a seven-bit address space, every one of the 128 possible first-byte addresses is sent twice, once armed and once not, with the stop interrupt enable toggled by address, so every extension-code and match pattern and the stop-interrupt suppression are covered arithmetically. The small guard count lets the bench check the STOP hold-off cycle by cycle.

// File: rtl/i2c_wake_ctl.sv
module i2c_wake_ctl #(
  parameter int SYNC_STAGES  = 2,
  parameter int GUARD_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [6:0] own_addr,
  input  logic       if_en,
  input  logic       stop_ie,
  input  logic       mst_busy,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_q,
  input  logic       start_req,
  output logic       start_ok,
  input  logic       wait_req,
  output logic       wait_ok,
  input  logic       txd_req,
  output logic       txd_ok,
  input  logic       stop_req,
  output logic       stop_grant,
  output logic       irq,
  output logic       wake,
  output logic       bus_busy,
  output logic       addr_hit,
  output logic       ext_hit
);
  localparam int GW = $clog2(GUARD_CYCLES + 1);
  localparam logic [GW-1:0] GMAX = GW'(GUARD_CYCLES);

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic scl_p, sda_p;
  logic wake_en, cfg_fm, cfg_df, cfg_ps, woke, mst_lock, in_addr;
  logic [GW-1:0] gcnt;
  logic [2:0] bit_cnt;
  logic [6:0] sh;

  wire scl_s = scl_sy[SYNC_STAGES-1];
  wire sda_s = sda_sy[SYNC_STAGES-1];
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire scl_rise  = scl_s & ~scl_p;
  wire [7:0] full = {sh, sda_s};
  wire is_ext   = (full[7:4] == 4'b0000) || (full[7:3] == 5'b11110);
  wire is_match = (full[7:1] == own_addr) && !is_ext;
  wire byte_done = in_addr && scl_rise && (bit_cnt == 3'd7);
  wire hit = is_ext || is_match;
  wire arm_set = wr_en && wr_data[7] && !wake_en && !mst_busy && !bus_busy && !addr_hit && !ext_hit;
  wire arm_clr = wr_en && !wr_data[7] && wake_en;
  wire unused_wr = ^{wr_data[6:4], wr_data[1]};

  assign ctrl_q     = {wake_en, 1'b0, scl_s, sda_s, cfg_fm, cfg_df, 1'b0, cfg_ps};
  assign start_ok   = start_req && !mst_lock && !wake_en;
  assign wait_ok    = wait_req && !wake_en;
  assign txd_ok     = txd_req && !wake_en;
  assign stop_grant = stop_req && (!wake_en || gcnt == GMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '0;
      sda_sy <= '0;
      scl_p  <= 1'b0;
      sda_p  <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_in};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_in};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_en <= 1'b0;
      cfg_fm  <= 1'b0;
      cfg_df  <= 1'b0;
      cfg_ps  <= 1'b0;
      woke    <= 1'b0;
      mst_lock <= 1'b0;
      gcnt    <= '0;
    end else begin
      if (wr_en && !if_en) begin
        cfg_fm <= wr_data[3];
        cfg_df <= wr_data[2];
        cfg_ps <= wr_data[0];
      end
      if (arm_set) wake_en <= 1'b1;
      else if (arm_clr) wake_en <= 1'b0;
      if (arm_set || arm_clr) woke <= 1'b0;
      else if (byte_done && hit && wake_en) woke <= 1'b1;
      if (arm_clr && !woke) mst_lock <= 1'b1;
      else if (start_det || stop_det) mst_lock <= 1'b0;
      if (arm_set) gcnt <= '0;
      else if (wake_en && gcnt != GMAX) gcnt <= gcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_busy <= 1'b0;
      in_addr  <= 1'b0;
      bit_cnt  <= '0;
      sh       <= '0;
      addr_hit <= 1'b0;
      ext_hit  <= 1'b0;
      irq      <= 1'b0;
      wake     <= 1'b0;
    end else begin
      irq  <= (byte_done && hit) || (stop_det && stop_ie && !wake_en);
      wake <= byte_done && hit && wake_en;
      if (start_det) bus_busy <= 1'b1;
      else if (stop_det) bus_busy <= 1'b0;
      if (start_det || stop_det) begin
        in_addr  <= start_det;
        bit_cnt  <= '0;
        addr_hit <= 1'b0;
        ext_hit  <= 1'b0;
      end else if (in_addr && scl_rise) begin
        sh      <= full[6:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == 3'd7) begin
          in_addr  <= 1'b0;
          addr_hit <= is_match;
          ext_hit  <= is_ext;
        end
      end
    end
  end

  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(if_en) |-> $stable({cfg_fm, cfg_df, cfg_ps}));
  a_r4_arm_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_en) |-> $past(!mst_busy && !bus_busy && !addr_hit && !ext_hit));
  a_r5_no_stop_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en && stop_det && !byte_done) |=> !irq);
  a_r7_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_en) |-> !stop_grant);
  a_r8_start_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wake_en) && !$past(woke)) |-> !start_ok);
  a_r6_wake_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> irq);
endmodule

// File: tb/i2c_wake_ctl_bench.sv
`timescale 1ns/100ps
module i2c_wake_ctl_bench;
  localparam logic [6:0] OWN = 7'h5A;
  localparam int HB = 4;

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda = 1;
  logic if_en = 0, stop_ie = 0, mst_busy = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic start_req = 0, wait_req = 0, txd_req = 0, stop_req = 0;
  logic [7:0] ctrl_q;
  logic start_ok, wait_ok, txd_ok, stop_grant, irq, wake, bus_busy, addr_hit, ext_hit;
  int total = 0, bad = 0, irq_n = 0, wake_n = 0;

  always #2.5 clk = ~clk;

  i2c_wake_ctl u_i2c_wake_ctl (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .own_addr(OWN),
    .if_en(if_en), .stop_ie(stop_ie), .mst_busy(mst_busy), .wr_en(wr_en),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .start_req(start_req), .start_ok(start_ok),
    .wait_req(wait_req), .wait_ok(wait_ok), .txd_req(txd_req), .txd_ok(txd_ok),
    .stop_req(stop_req), .stop_grant(stop_grant), .irq(irq), .wake(wake),
    .bus_busy(bus_busy), .addr_hit(addr_hit), .ext_hit(ext_hit));

  always @(posedge clk) if (rst_n) begin
    if (irq) irq_n++;
    if (wake) wake_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    repeat (HB) @(negedge clk);
  endtask

  task automatic set_scl(input logic v); @(negedge clk); scl = v; step(); endtask
  task automatic set_sda(input logic v); @(negedge clk); sda = v; step(); endtask

  task automatic bus_start(); set_sda(0); set_scl(0); endtask
  task automatic bus_stop(); set_sda(0); set_scl(1); set_sda(1); endtask

  task automatic send_byte(input logic [7:0] b, input bit timed);
    for (int i = 7; i >= 0; i--) begin
      set_sda(b[i]);
      if (timed && i == 0) begin
        @(negedge clk); scl = 1;
        repeat (2) @(posedge clk);
        @(negedge clk); chk(irq == 0, "R6 irq early", irq, 0);
        @(posedge clk);
        @(negedge clk); chk(irq == 1, "R6 irq on third edge", irq, 1);
        chk(wake == 0, "R6 no wake unarmed", wake, 0);
        @(posedge clk);
        @(negedge clk); chk(irq == 0, "R6 irq one cycle", irq, 0);
        step();
      end else set_scl(1);
      set_scl(0);
    end
  endtask

  task automatic reg_write(input logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic sweep(input bit armed);
    for (int a = 0; a < 128; a++) begin
      int i0, w0, exp_i;
      logic [7:0] b;
      bit e, m;
      b = {a[6:0], 1'b0};
      e = (b[7:4] == 4'b0000) || (b[7:3] == 5'b11110);
      m = (a[6:0] == OWN) && !e;
      stop_ie = a[0];
      i0 = irq_n; w0 = wake_n;
      bus_start();
      send_byte(b, 0);
      step();
      chk(ext_hit == e, "R10 ext_hit", ext_hit, e);
      chk(addr_hit == m, "R11 addr_hit", addr_hit, m);
      bus_stop();
      step();
      exp_i = int'(e | m) + ((!armed && stop_ie) ? 1 : 0);
      chk(irq_n - i0 == exp_i, armed ? "R5 armed irq count" : "R5 unarmed irq count", irq_n - i0, exp_i);
      chk(wake_n - w0 == (armed ? int'(e | m) : 0), "R6 wake count", wake_n - w0, armed ? int'(e | m) : 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ctrl_q == 8'h00, "R1 reset value", ctrl_q, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk(ctrl_q == 8'h00, "R1 first cycle", ctrl_q, 8'h00);
    step();
    chk(ctrl_q == 8'h30, "R2 idle levels", ctrl_q, 8'h30);
    set_scl(0); chk(ctrl_q == 8'h10, "R2 scl low", ctrl_q, 8'h10);
    set_sda(0); chk(ctrl_q == 8'h00, "R2 both low", ctrl_q, 8'h00);
    set_scl(1); chk(ctrl_q == 8'h20, "R2 sda low", ctrl_q, 8'h20);
    set_sda(1); chk(bus_busy == 0, "R12 idle after stop", bus_busy, 0);

    reg_write(8'h7F);
    chk(ctrl_q == 8'h3D, "R2 R3 write with if_en 0", ctrl_q, 8'h3D);
    reg_write(8'h0D);
    if_en = 1;
    reg_write(8'h00);
    chk(ctrl_q == 8'h3D, "R3 write ignored when enabled", ctrl_q, 8'h3D);

    stop_req = 1;
    @(negedge clk);
    chk(stop_grant == 1, "R7 unarmed grant", stop_grant, 1);
    reg_write(8'h8D);
    chk(ctrl_q == 8'hBD, "R4 arm accepted while idle", ctrl_q, 8'hBD);
    chk(stop_grant == 0, "R7 guard cycle 1", stop_grant, 0);
    @(negedge clk); chk(stop_grant == 0, "R7 guard cycle 2", stop_grant, 0);
    @(negedge clk); chk(stop_grant == 0, "R7 guard cycle 3", stop_grant, 0);
    @(negedge clk); chk(stop_grant == 1, "R7 grant after guard", stop_grant, 1);
    stop_req = 0;
    wait_req = 1; txd_req = 1; start_req = 1;
    #1;
    chk(wait_ok == 0 && txd_ok == 0, "R9 refused while armed", {wait_ok, txd_ok}, 0);
    chk(start_ok == 0, "R8 no start while armed", start_ok, 0);
    wait_req = 0; txd_req = 0; start_req = 0;

    sweep(1);

    reg_write(8'h0D);
    wait_req = 1; txd_req = 1; start_req = 1;
    #1;
    chk(wait_ok == 1 && txd_ok == 1, "R9 accepted after clear", {wait_ok, txd_ok}, 3);
    chk(start_ok == 1, "R8 start allowed after wake clear", start_ok, 1);
    start_req = 0; wait_req = 0; txd_req = 0;

    reg_write(8'h8D);
    reg_write(8'h0D);
    start_req = 1; #1;
    chk(start_ok == 0, "R8 start locked after plain clear", start_ok, 0);
    bus_start();
    #1;
    chk(start_ok == 1, "R8 lock released by start", start_ok, 1);
    chk(bus_busy == 1, "R12 busy after start", bus_busy, 1);
    start_req = 0;
    reg_write(8'h8D);
    chk(ctrl_q[7] == 0, "R4 arm refused while busy", ctrl_q[7], 0);
    set_scl(1); set_sda(1);
    chk(bus_busy == 0, "R12 idle after stop", bus_busy, 0);
    mst_busy = 1;
    reg_write(8'h8D);
    chk(ctrl_q[7] == 0, "R4 arm refused in master", ctrl_q[7], 0);
    mst_busy = 0;
    reg_write(8'h8D);
    chk(ctrl_q[7] == 1, "R4 arm accepted", ctrl_q[7], 1);
    reg_write(8'h0D);
    chk(ctrl_q[7] == 0, "R4 clear accepted", ctrl_q[7], 0);

    stop_ie = 0;
    bus_start();
    send_byte({OWN, 1'b1}, 1);
    chk(addr_hit == 1, "R11 own address with read bit", addr_hit, 1);
    bus_stop();
    step();

    sweep(0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule